// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits between a converter's sample path and its output serializer. On every sample it presents one parallel word. With the pattern selector at zero that word is the live sample. Other selector codes replace it with a known test word, so that a receiver can check its capture and bit alignment against an expected sequence. The patterns are fixed codes, word pairs that alternate on each sample, single-bit toggles, user-programmed word pairs, and two pseudo-random sequences: a 9-stage one and a 23-stage one.

The output is either 12 or 14 bits wide, chosen by a resolution select. A narrow word sits right-aligned in the 14-bit port, and its two top bits are zero. A per-sample strobe moves the alternating and pseudo-random patterns forward. The word on the port is combinational from the current inputs and the stored pattern state. The stored state changes only at a clock edge.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: Selector codes 0 (0000), 13, 14 and 15 pass `live_i` to `word_o`, masked to the selected width.
- R2: Fixed words. Code 1 (0001) and code 11 (1011) give only the top bit set: 0x2000 wide, 0x800 narrow. Code 2 gives all ones. Code 3 gives all zeros. Code 9 (1001) gives the 1010... word: 0x2AAA wide, 0xAAA narrow.
- R3: Code 10 (1010) gives the sync word, 0x007F wide and 0x03F narrow. Code 12 (1100) gives the mixed-frequency word, 0x2867 wide and 0xA33 narrow.
- R4: Code 4 (0100) alternates on each strobe. First word: 1010... (0x2AAA / 0xAAA). Second word: 0101... (0x1555 / 0x555).
- R5: Code 7 (0111) alternates on each strobe between all ones (first) and all zeros (second).
- R6: Code 8 (1000) alternates on each strobe between `user_a_i` (first) and `user_b_i` (second), each masked to the width.
- R7: Code 6 (0110) outputs a PN sequence from a Fibonacci register for x^9 + x^5 + 1. The register is seeded with all ones. Each new bit is stage 9 XOR stage 5, and it shifts in at the bottom. Each word takes the next 12 or 14 generated bits, with the first bit in the MSB. Each strobe consumes one word.
- R8: Code 5 (0101) outputs a PN sequence the same way as R7, but from a 23-stage register for x^23 + x^18 + 1. Each new bit is stage 23 XOR stage 18.
- R9: After reset, and in the very cycle the selector code changes, alternating patterns show their first word and PN generators show the seed word. This holds even when the strobe is high in that cycle. That strobe then moves the pattern on to its next word.
- R10: While `adv_i` is low and neither the selector nor the width changes, the output word holds its value.
- R11: With `res14_i` low, `word_o[13:12]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 4 | Pattern selector code |
| res14_i | input | 1 | 1 = 14-bit words, 0 = 12-bit words |
| user_a_i | input | 14 | First user-programmed word |
| user_b_i | input | 14 | Second user-programmed word |
| adv_i | input | 1 | Per-sample advance strobe |
| live_i | input | 14 | Live converter sample |
| word_o | output | 14 | Output word to the serializer |

## Verification
A change of selector code and an advance strobe can arrive in the same cycle. The restart must then win for the word shown in that cycle, and the strobe must still take effect at the edge. The bench provokes this in two ways: it leaves an alternating pattern on its second word and switches to another alternating pattern with the strobe held high, and it leaves a PN mode and then returns to it. In the cycle of the change the output must be the first word or the seed word. In the following cycle it must be the second word or the next PN word.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam int WIDE_W   = 14;
    localparam int NARROW_W = 12;

    typedef logic [WIDE_W-1:0] word_t;

    typedef enum logic [3:0] {
        TP_LIVE        = 4'd0,
        TP_MID         = 4'd1,
        TP_POS_FS      = 4'd2,
        TP_NEG_FS      = 4'd3,
        TP_CHECKER     = 4'd4,
        TP_PN_LONG     = 4'd5,
        TP_PN_SHORT    = 4'd6,
        TP_WORD_TOGGLE = 4'd7,
        TP_USER        = 4'd8,
        TP_BIT_TOGGLE  = 4'd9,
        TP_SYNC        = 4'd10,
        TP_ONE_HIGH    = 4'd11,
        TP_MIXED       = 4'd12
    } tp_mode_e;

    typedef struct packed {
        logic     wide;
        logic     second;
        tp_mode_e mode;
    } pat_sel_t;

    function automatic word_t width_mask(input logic wide);
        word_t m;
        for (int i = 0; i < WIDE_W; i++) m[i] = wide || (i < NARROW_W);
        return m;
    endfunction

    // Odd bit positions set: the MSB is 1 in both widths.
    function automatic word_t alt_word();
        word_t w;
        for (int i = 0; i < WIDE_W; i++) w[i] = (i % 2) == 1;
        return w;
    endfunction

    function automatic word_t top_bit_word(input logic wide);
        word_t w = '0;
        w[wide ? WIDE_W-1 : NARROW_W-1] = 1'b1;
        return w;
    endfunction

    function automatic word_t sync_word(input logic wide);
        word_t w;
        for (int i = 0; i < WIDE_W; i++)
            w[i] = i < ((wide ? WIDE_W : NARROW_W) / 2);
        return w;
    endfunction

    function automatic word_t mixed_word(input logic wide);
        return wide ? word_t'(14'h2867) : word_t'(14'h0A33);
    endfunction
endpackage

// File: rtl/tpg_phase.sv
module tpg_phase (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] mode_i,
    input  logic       adv_i,
    output logic       restart_o,
    output logic       second_o
);
    logic [3:0] mode_q;
    logic       phase_q;

    assign restart_o = (mode_i != mode_q);
    assign second_o  = restart_o ? 1'b0 : phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 4'd0;
            phase_q <= 1'b0;
        end else begin
            mode_q  <= mode_i;
            phase_q <= second_o ^ adv_i;
        end
    end
endmodule

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
    parameter int LEN = 9,
    parameter int TAP = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reseed_i,
    input  logic           active_i,
    input  logic           adv_i,
    input  logic           wide_i,
    output tpg_pkg::word_t word_o
);
    import tpg_pkg::*;

    logic [LEN-1:0] st_q, st_eff, st_after_narrow, st_after_wide, st_next;
    logic [WIDE_W-1:0] gen_bits;

    assign st_eff = reseed_i ? '1 : st_q;

    always_comb begin
        logic [LEN-1:0] s;
        logic           fb;
        s               = st_eff;
        gen_bits        = '0;
        st_after_narrow = '0;
        for (int i = 0; i < WIDE_W; i++) begin
            fb          = s[LEN-1] ^ s[TAP-1];
            s           = {s[LEN-2:0], fb};
            gen_bits[i] = fb;
            if (i == NARROW_W-1) st_after_narrow = s;
        end
        st_after_wide = s;
        word_o = '0;
        for (int i = 0; i < WIDE_W; i++) begin
            if (wide_i)             word_o[WIDE_W-1-i]   = gen_bits[i];
            else if (i < NARROW_W)  word_o[NARROW_W-1-i] = gen_bits[i];
        end
        st_next = wide_i ? st_after_wide : st_after_narrow;
    end

    always_ff @(posedge clk) begin
        if (rst)                     st_q <= '1;
        else if (active_i && adv_i)  st_q <= st_next;
        else                         st_q <= st_eff;
    end
endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen #(
    parameter int PN_LONG_LEN  = 23,
    parameter int PN_LONG_TAP  = 18,
    parameter int PN_SHORT_LEN = 9,
    parameter int PN_SHORT_TAP = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  mode_i,
    input  logic        res14_i,
    input  logic [13:0] user_a_i,
    input  logic [13:0] user_b_i,
    input  logic        adv_i,
    input  logic [13:0] live_i,
    output logic [13:0] word_o
);
    import tpg_pkg::*;

    localparam int N_PN = 2;

    pat_sel_t sel;
    logic     restart;
    logic     second;
    word_t    pn_word [N_PN];
    word_t    raw;

    assign sel.mode   = tp_mode_e'(mode_i);
    assign sel.wide   = res14_i;
    assign sel.second = second;

    tpg_phase phase_i (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode_i),
        .adv_i     (adv_i),
        .restart_o (restart),
        .second_o  (second)
    );

    // Index 0: long sequence, index 1: short sequence.
    for (genvar g = 0; g < N_PN; g++) begin : g_pn
        localparam int LEN = (g == 0) ? PN_LONG_LEN : PN_SHORT_LEN;
        localparam int TAP = (g == 0) ? PN_LONG_TAP : PN_SHORT_TAP;
        localparam tp_mode_e OWN = (g == 0) ? TP_PN_LONG : TP_PN_SHORT;
        tpg_lfsr #(.LEN(LEN), .TAP(TAP)) lfsr_i (
            .clk      (clk),
            .rst      (rst),
            .reseed_i (restart),
            .active_i (sel.mode == OWN),
            .adv_i    (adv_i),
            .wide_i   (res14_i),
            .word_o   (pn_word[g])
        );
    end

    always_comb begin
        case (sel.mode)
            TP_MID, TP_ONE_HIGH: raw = top_bit_word(sel.wide);
            TP_POS_FS:           raw = '1;
            TP_NEG_FS:           raw = '0;
            TP_CHECKER:          raw = sel.second ? ~alt_word() : alt_word();
            TP_PN_LONG:          raw = pn_word[0];
            TP_PN_SHORT:         raw = pn_word[1];
            TP_WORD_TOGGLE:      raw = sel.second ? '0 : '1;
            TP_USER:             raw = sel.second ? user_b_i : user_a_i;
            TP_BIT_TOGGLE:       raw = alt_word();
            TP_SYNC:             raw = sync_word(sel.wide);
            TP_MIXED:            raw = mixed_word(sel.wide);
            default:             raw = live_i;
        endcase
        word_o = raw & width_mask(sel.wide);
    end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  mode_i,
    input logic        res14_i,
    input logic        adv_i,
    input logic [13:0] live_i,
    input logic [13:0] word_o
);
    logic        seen_q;
    logic [13:0] msk;

    assign msk = res14_i ? 14'h3FFF : 14'h0FFF;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    p_live_pass_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 4'd0 || mode_i >= 4'd13) |-> word_o == (live_i & msk));

    p_narrow_top_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !res14_i |-> word_o[13:12] == 2'b00);

    p_checker_flip_r4: assert property (@(posedge clk) disable iff (rst)
        (seen_q && mode_i == 4'd4 && $past(mode_i) == 4'd4 && $past(adv_i)
         && $stable(res14_i)) |-> word_o == (~$past(word_o) & msk));

    p_toggle_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (seen_q && mode_i == 4'd7 && $past(mode_i) != 4'd7) |-> word_o == msk);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(adv_i) && $stable(mode_i) && $stable(res14_i)
         && (mode_i == 4'd4 || mode_i == 4'd7 || mode_i == 4'd5 || mode_i == 4'd6))
        |-> $stable(word_o));
endmodule

bind adc_test_pattern_gen tpg_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_i),
    .res14_i (res14_i),
    .adv_i   (adv_i),
    .live_i  (live_i),
    .word_o  (word_o)
);

// File: tb/adc_test_pattern_gen_tb_top.sv
module adc_test_pattern_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  mode;
    logic        res14;
    logic [13:0] user_a, user_b, live;
    logic        adv;
    logic [13:0] word;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #5 clk = ~clk;

    adc_test_pattern_gen dut_i (
        .clk(clk), .rst(rst), .mode_i(mode), .res14_i(res14),
        .user_a_i(user_a), .user_b_i(user_b), .adv_i(adv),
        .live_i(live), .word_o(word)
    );

    task automatic chk(input string tag, input logic [13:0] exp);
        n_cmp++;
        if (word !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, word, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] m, input logic w, input logic a,
                       input logic [13:0] l);
        @(negedge clk);
        mode = m; res14 = w; adv = a; live = l;
        #1;
    endtask

    task automatic pn_gen(inout logic [22:0] st, input int len, input int tap,
                          input logic w, output logic [13:0] out);
        int  n = w ? 14 : 12;
        logic b;
        out = '0;
        for (int i = 0; i < n; i++) begin
            b  = st[len-1] ^ st[tap-1];
            st = ((st << 1) | 23'(b)) & ((23'd1 << len) - 23'd1);
            out[n-1-i] = b;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; mode = 4'd0; res14 = 1'b1; adv = 1'b0; live = 14'h1234;
        user_a = 14'h0; user_b = 14'h0;
        repeat (3) @(posedge clk);
        cyc(4'd0, 1'b1, 1'b0, 14'h1234);
        chk("R1 reset passthrough", 14'h1234);
        @(negedge clk); rst = 1'b0; mode = 4'd7; #1;
        chk("R9 word1 after reset", 14'h3FFF);
    endtask

    task automatic t_passthrough();
        cyc(4'd0, 1'b1, 1'b1, 14'h3ABC); chk("R1 mode0 wide", 14'h3ABC);
        cyc(4'd0, 1'b0, 1'b0, 14'h3ABC); chk("R1 mode0 narrow R11", 14'h0ABC);
        cyc(4'd13, 1'b1, 1'b0, 14'h2222); chk("R1 mode13", 14'h2222);
        cyc(4'd14, 1'b1, 1'b1, 14'h1111); chk("R1 mode14", 14'h1111);
        cyc(4'd15, 1'b0, 1'b0, 14'h3F0F); chk("R1 mode15 narrow", 14'h0F0F);
    endtask

    task automatic t_fixed();
        cyc(4'd1, 1'b1, 1'b1, 14'h3FFF); chk("R2 mid wide", 14'h2000);
        cyc(4'd1, 1'b0, 1'b1, 14'h3FFF); chk("R2 mid narrow", 14'h0800);
        cyc(4'd2, 1'b1, 1'b0, 14'h0);    chk("R2 pos fs wide", 14'h3FFF);
        cyc(4'd2, 1'b0, 1'b0, 14'h0);    chk("R2 pos fs narrow", 14'h0FFF);
        cyc(4'd3, 1'b1, 1'b0, 14'h3FFF); chk("R2 neg fs", 14'h0000);
        cyc(4'd9, 1'b1, 1'b1, 14'h0);    chk("R2 bit toggle wide", 14'h2AAA);
        cyc(4'd9, 1'b0, 1'b1, 14'h0);    chk("R2 bit toggle narrow", 14'h0AAA);
        cyc(4'd11, 1'b1, 1'b0, 14'h0);   chk("R2 one high wide", 14'h2000);
        cyc(4'd11, 1'b0, 1'b0, 14'h0);   chk("R2 one high narrow", 14'h0800);
        cyc(4'd10, 1'b1, 1'b1, 14'h0);   chk("R3 sync wide", 14'h007F);
        cyc(4'd10, 1'b0, 1'b1, 14'h0);   chk("R3 sync narrow", 14'h003F);
        cyc(4'd12, 1'b1, 1'b0, 14'h0);   chk("R3 mixed wide", 14'h2867);
        cyc(4'd12, 1'b0, 1'b0, 14'h0);   chk("R3 mixed narrow", 14'h0A33);
    endtask

    task automatic t_checker();
        cyc(4'd4, 1'b1, 1'b1, 14'h0); chk("R4 word1", 14'h2AAA);
        cyc(4'd4, 1'b1, 1'b1, 14'h0); chk("R4 word2", 14'h1555);
        cyc(4'd4, 1'b1, 1'b0, 14'h0); chk("R4 back to word1", 14'h2AAA);
        cyc(4'd4, 1'b1, 1'b1, 14'h0); chk("R10 hold word1", 14'h2AAA);
        cyc(4'd4, 1'b0, 1'b0, 14'h0); chk("R4 narrow word2", 14'h0555);
    endtask

    task automatic t_toggle();
        cyc(4'd0, 1'b1, 1'b0, 14'h0);
        cyc(4'd7, 1'b1, 1'b1, 14'h0); chk("R5 ones", 14'h3FFF);
        cyc(4'd7, 1'b1, 1'b1, 14'h0); chk("R5 zeros", 14'h0000);
        cyc(4'd7, 1'b0, 1'b0, 14'h0); chk("R5 narrow ones", 14'h0FFF);
    endtask

    task automatic t_user();
        user_a = 14'h3C5A; user_b = 14'h1234;
        cyc(4'd8, 1'b1, 1'b1, 14'h0); chk("R6 user a", 14'h3C5A);
        cyc(4'd8, 1'b1, 1'b1, 14'h0); chk("R6 user b", 14'h1234);
        cyc(4'd8, 1'b0, 1'b1, 14'h0); chk("R6 user a narrow", 14'h0C5A);
        cyc(4'd8, 1'b0, 1'b0, 14'h0); chk("R6 user b narrow", 14'h0234);
    endtask

    task automatic t_pn(input logic [3:0] m, input int len, input int tap,
                        input logic w, input string tag);
        logic [22:0] st;
        logic [13:0] e;
        cyc(4'd0, w, 1'b0, 14'h0);
        st = (23'd1 << len) - 23'd1;
        for (int k = 0; k < 6; k++) begin
            cyc(m, w, 1'b1, 14'h0);
            pn_gen(st, len, tap, w, e);
            chk(tag, e);
        end
        begin
            logic [22:0] peek = st;
            pn_gen(peek, len, tap, w, e);
        end
        cyc(m, w, 1'b0, 14'h0); chk({tag, " R10 hold"}, e);
        cyc(m, w, 1'b0, 14'h0); chk({tag, " R10 hold again"}, e);
        cyc(4'd0, w, 1'b1, 14'h0);
        st = (23'd1 << len) - 23'd1;
        pn_gen(st, len, tap, w, e);
        cyc(m, w, 1'b1, 14'h0); chk({tag, " R9 reseed"}, e);
        pn_gen(st, len, tap, w, e);
        cyc(m, w, 1'b0, 14'h0); chk({tag, " R9 after reseed"}, e);
    endtask

    task automatic t_restart();
        cyc(4'd4, 1'b1, 1'b1, 14'h0); chk("R9 setup checker word1", 14'h2AAA);
        cyc(4'd8, 1'b1, 1'b1, 14'h0); chk("R9 change with strobe", 14'h3C5A);
        cyc(4'd7, 1'b1, 1'b1, 14'h0); chk("R9 change again", 14'h3FFF);
        cyc(4'd7, 1'b1, 1'b0, 14'h0); chk("R9 strobe took effect", 14'h0000);
        cyc(4'd4, 1'b1, 1'b0, 14'h0); chk("R9 back to checker", 14'h2AAA);
    endtask

    initial begin
        t_reset();
        t_passthrough();
        t_fixed();
        t_checker();
        t_toggle();
        t_user();
        t_pn(4'd6, 9, 5, 1'b1, "R7 pn9 wide");
        t_pn(4'd6, 9, 5, 1'b0, "R7 pn9 narrow R11");
        t_pn(4'd5, 23, 18, 1'b1, "R8 pn23 wide");
        t_pn(4'd5, 23, 18, 1'b0, "R8 pn23 narrow");
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule